// File: doc/BRIEF.md
# Fully Associative LRU Tag Store with Multi-Capacity Hit Tracking

This block is the tag side of a fully associative cache. Every entry holds the whole block address and a secure bit, and all entries sit in one true least-recently-used order. A requester issues one operation per cycle: an access lookup that refreshes recency, a probe that only reports presence, victim selection, insertion into a named entry, or invalidation of a named entry. The hit flag, entry index and capacity mask are combinational on the request cycle. Recency and counter updates take effect at the next clock edge.

Beside the real cache, the block measures how smaller caches would have behaved on the same access stream. The tracked capacities start at `MIN_BLOCKS` entries and double up to, but not including, `ENTRIES`. The recency rank of a hit entry shows which of these capacities would still hold it. One stack therefore yields per-capacity hit and miss counts, along with a total access count.

Data storage, coherence state and the refill path sit outside this block. A fill is done as a victim request followed by an insert into the index that the victim request returned.

Top module: `fa_lru_tags`

## Requirements
- R1: A lookup or probe hits only when a valid entry has exactly equal block address and equal secure bit. On a miss the response index is 0.
- R2: After reset every entry is invalid, all counters read 0, and recency follows index order: entry 0 is most recent and entry ENTRIES-1 is least recent.
- R3: A probe (op 1) reports hit, index and mask but changes neither the recency order nor any counter.
- R4: An access lookup (op 0) that hits moves the matched entry to most-recent. Entries that were more recent than it each move back one place.
- R5: Victim selection (op 4) returns the index of the least-recently-used entry, with hit and mask at 0.
- R6: An insert (op 2) writes the address and secure bit into entry req_idx, marks it valid and makes it most-recent. No operation has any effect while req_valid is low.
- R7: An invalidate (op 3) clears the valid bit of entry req_idx and makes it least-recent, so it is the next victim. Entries that were less recent move forward one place.
- R8: On a hit, mask bit k is 1 exactly when the entry's recency rank (0 = most recent) is below MIN_BLOCKS<<k, for k below the tracked count log2(ENTRIES)-log2(MIN_BLOCKS). Bit 0 is the smallest capacity. All other bits, and the whole mask on a miss, are 0. A tracked count above MASK_W is rejected at elaboration.
- R9: Each access lookup increments the access counter. For every tracked capacity k, it increments hit counter k if mask bit k is set and miss counter k otherwise. Capacity k occupies bits [k*CNT_W +: CNT_W] of hit_cnt and miss_cnt.
- R10: All counters saturate at their all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 lookup, 1 probe, 2 insert, 3 invalidate, 4 victim |
| req_addr | input | ADDR_W | Block address |
| req_secure | input | 1 | Secure-space bit of the request |
| req_idx | input | $clog2(ENTRIES) | Target entry for insert and invalidate |
| rsp_hit | output | 1 | Lookup or probe found the block |
| rsp_idx | output | $clog2(ENTRIES) | Matched entry, victim entry, or echoed target |
| rsp_mask | output | MASK_W | Tracked capacities that hold the hit entry |
| acc_cnt | output | CNT_W | Access lookup count |
| hit_cnt | output | max(tracked,1)*CNT_W | Per-capacity hit counts |
| miss_cnt | output | max(tracked,1)*CNT_W | Per-capacity miss counts |

## Verification
Hit, index and mask are due in the same cycle as the request. The bench drives each request on a falling edge and samples these outputs 1 ns later, before the rising edge that commits the request. Recency and counter changes are due one rising edge after the request. They are observed at the following falling edge, either on the counter ports or through the index and mask of the next probe or victim request. The expected masks in the table come from working out, step by step, the recency ranks that the preceding requests produce.

// File: rtl/fa_lru_pkg.sv
`timescale 1ns/1ps
package fa_lru_pkg;
    typedef enum logic [2:0] {
        OP_LOOKUP = 3'd0,
        OP_PROBE  = 3'd1,
        OP_INSERT = 3'd2,
        OP_INVAL  = 3'd3,
        OP_VICTIM = 3'd4
    } op_e;
endpackage

// File: rtl/fa_tag_match.sv
`timescale 1ns/1ps
module fa_tag_match #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned ADDR_W  = 16,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ENTRIES-1:0]             secure,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tag,
    input  logic [ADDR_W-1:0]              key_addr,
    input  logic                           key_secure,
    output logic                           hit,
    output logic [IDX_W-1:0]               idx
);
    logic [ENTRIES-1:0] eq;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign eq[i] = valid[i] && (secure[i] == key_secure) && (tag[i] == key_addr);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end

    assign hit = |eq;
endmodule

// File: rtl/fa_lru_pick.sv
`timescale 1ns/1ps
module fa_lru_pick #(
    parameter int unsigned ENTRIES = 8,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0][IDX_W-1:0] rank,
    output logic [IDX_W-1:0]              lru_idx
);
    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rank[i] == IDX_W'(ENTRIES - 1)) lru_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/fa_fit_mask.sv
`timescale 1ns/1ps
module fa_fit_mask #(
    parameter int unsigned ENTRIES    = 8,
    parameter int unsigned MIN_BLOCKS = 2,
    parameter int unsigned NUM_TRACK  = 2,
    parameter int unsigned MASK_W     = 8,
    localparam int unsigned IDX_W     = $clog2(ENTRIES)
) (
    input  logic [IDX_W-1:0]  rank,
    output logic [MASK_W-1:0] fit
);
    for (genvar k = 0; k < MASK_W; k++) begin : g_bit
        if (k < NUM_TRACK) begin : g_trk
            assign fit[k] = (32'(rank) < (MIN_BLOCKS << k));
        end else begin : g_off
            assign fit[k] = 1'b0;
        end
    end
endmodule

// File: rtl/fa_lru_tags.sv
`timescale 1ns/1ps
module fa_lru_tags
    import fa_lru_pkg::*;
#(
    parameter int unsigned ENTRIES    = 8,
    parameter int unsigned MIN_BLOCKS = 2,
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned MASK_W     = 8,
    localparam int unsigned IDX_W     = $clog2(ENTRIES),
    localparam int unsigned NUM_TRACK = (ENTRIES > MIN_BLOCKS) ?
                                        ($clog2(ENTRIES) - $clog2(MIN_BLOCKS)) : 0,
    localparam int unsigned TRK_W     = (NUM_TRACK > 0) ? NUM_TRACK : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [2:0]               req_op,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_secure,
    input  logic [IDX_W-1:0]         req_idx,
    output logic                     rsp_hit,
    output logic [IDX_W-1:0]         rsp_idx,
    output logic [MASK_W-1:0]        rsp_mask,
    output logic [CNT_W-1:0]         acc_cnt,
    output logic [TRK_W*CNT_W-1:0]   hit_cnt,
    output logic [TRK_W*CNT_W-1:0]   miss_cnt
);
    if (NUM_TRACK > MASK_W) begin : g_bad_cfg
        $error("tracked capacity count exceeds mask width");
    end

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0]             secure;
        logic [ENTRIES-1:0][ADDR_W-1:0] tag;
        logic [ENTRIES-1:0][IDX_W-1:0]  rank;
        logic [CNT_W-1:0]               acc;
        logic [TRK_W-1:0][CNT_W-1:0]    hits;
        logic [TRK_W-1:0][CNT_W-1:0]    misses;
    } state_t;

    state_t st_d, st_q;

    op_e                op;
    logic               match_hit;
    logic [IDX_W-1:0]   match_idx;
    logic [IDX_W-1:0]   lru_idx;
    logic [MASK_W-1:0]  fit;
    logic               prom, dem;
    logic [IDX_W-1:0]   tgt;

    logic [ENTRIES-1:0][IDX_W-1:0] rank_q;
    logic [ENTRIES-1:0]            valid_q;

    assign op      = op_e'(req_op);
    assign rank_q  = st_q.rank;
    assign valid_q = st_q.valid;

    fa_tag_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
        .valid      (st_q.valid),
        .secure     (st_q.secure),
        .tag        (st_q.tag),
        .key_addr   (req_addr),
        .key_secure (req_secure),
        .hit        (match_hit),
        .idx        (match_idx)
    );

    fa_lru_pick #(.ENTRIES(ENTRIES)) u_pick (
        .rank    (st_q.rank),
        .lru_idx (lru_idx)
    );

    fa_fit_mask #(
        .ENTRIES(ENTRIES), .MIN_BLOCKS(MIN_BLOCKS),
        .NUM_TRACK(NUM_TRACK), .MASK_W(MASK_W)
    ) u_fit (
        .rank (st_q.rank[match_idx]),
        .fit  (fit)
    );

    function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

    // Response path: combinational on the request cycle
    always_comb begin
        rsp_hit  = req_valid && (op == OP_LOOKUP || op == OP_PROBE) && match_hit;
        rsp_mask = rsp_hit ? fit : '0;
        if (op == OP_VICTIM)                       rsp_idx = lru_idx;
        else if (op == OP_LOOKUP || op == OP_PROBE) rsp_idx = match_idx;
        else                                        rsp_idx = req_idx;
    end

    // Next-state computation
    always_comb begin
        st_d = st_q;
        prom = 1'b0;
        dem  = 1'b0;
        tgt  = req_idx;
        if (req_valid) begin
            case (op)
                OP_LOOKUP: begin
                    st_d.acc = bump(st_q.acc);
                    for (int k = 0; k < NUM_TRACK; k++) begin
                        if (match_hit && fit[k]) st_d.hits[k]   = bump(st_q.hits[k]);
                        else                     st_d.misses[k] = bump(st_q.misses[k]);
                    end
                    prom = match_hit;
                    tgt  = match_idx;
                end
                OP_INSERT: begin
                    st_d.valid[req_idx]  = 1'b1;
                    st_d.secure[req_idx] = req_secure;
                    st_d.tag[req_idx]    = req_addr;
                    prom = 1'b1;
                end
                OP_INVAL: begin
                    st_d.valid[req_idx] = 1'b0;
                    dem = 1'b1;
                end
                default: ;
            endcase
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (prom) begin
                if (IDX_W'(i) == tgt)                  st_d.rank[i] = '0;
                else if (st_q.rank[i] < st_q.rank[tgt]) st_d.rank[i] = st_q.rank[i] + 1'b1;
            end else if (dem) begin
                if (IDX_W'(i) == tgt)                  st_d.rank[i] = IDX_W'(ENTRIES - 1);
                else if (st_q.rank[i] > st_q.rank[tgt]) st_d.rank[i] = st_q.rank[i] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                st_q.rank[i] <= IDX_W'(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_cnt  = st_q.acc;
    assign hit_cnt  = st_q.hits;
    assign miss_cnt = st_q.misses;
endmodule

// File: rtl/fa_lru_tags_chk.sv
`timescale 1ns/1ps
module fa_lru_tags_chk
    import fa_lru_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned MASK_W  = 8,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_valid,
    input logic [2:0]                    req_op,
    input logic [IDX_W-1:0]              req_idx,
    input logic                          rsp_hit,
    input logic [MASK_W-1:0]             rsp_mask,
    input logic [CNT_W-1:0]              acc_cnt,
    input logic [ENTRIES-1:0][IDX_W-1:0] rank,
    input logic [ENTRIES-1:0]            valid
);
    logic [ENTRIES-1:0] seen;
    always_comb begin
        seen = '0;
        for (int i = 0; i < ENTRIES; i++) seen[rank[i]] = 1'b1;
    end

    // R4: recency ranks always form a permutation
    p_rank_perm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        &seen);

    // R3: probe leaves recency and the access counter alone
    p_probe_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == OP_PROBE |=> $stable(rank) && $stable(acc_cnt));

    // R6: inserted entry is valid and most recent
    p_insert_mru_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == OP_INSERT |=> rank[$past(req_idx)] == '0 && valid[$past(req_idx)]);

    // R7: invalidated entry is invalid and least recent
    p_inval_lru_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == OP_INVAL |=>
        rank[$past(req_idx)] == IDX_W'(ENTRIES - 1) && !valid[$past(req_idx)]);

    // R8: mask is empty without a hit
    p_mask_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> rsp_mask == '0);

    // R9: each access lookup counts once
    p_acc_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == OP_LOOKUP && !(&acc_cnt) |=> acc_cnt == $past(acc_cnt) + 1'b1);

    // R10: a saturated counter stays saturated
    p_acc_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        &acc_cnt |=> &acc_cnt);
endmodule

bind fa_lru_tags fa_lru_tags_chk #(
    .ENTRIES(ENTRIES), .CNT_W(CNT_W), .MASK_W(MASK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_idx   (req_idx),
    .rsp_hit   (rsp_hit),
    .rsp_mask  (rsp_mask),
    .acc_cnt   (acc_cnt),
    .rank      (rank_q),
    .valid     (valid_q)
);

// File: tb/fa_lru_tags_test.sv
`timescale 1ns/1ps
module fa_lru_tags_test;
    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [15:0] req_addr = '0;
    logic        req_secure = 1'b0;
    logic [2:0]  req_idx = '0;
    logic        rsp_hit;
    logic [2:0]  rsp_idx;
    logic [7:0]  rsp_mask;
    logic [CW-1:0]   acc_cnt;
    logic [2*CW-1:0] hit_cnt, miss_cnt;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fa_lru_tags #(.ENTRIES(8), .MIN_BLOCKS(2), .ADDR_W(16), .CNT_W(CW), .MASK_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_secure(req_secure), .req_idx(req_idx),
        .rsp_hit(rsp_hit), .rsp_idx(rsp_idx), .rsp_mask(rsp_mask),
        .acc_cnt(acc_cnt), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
    );

    localparam logic [2:0] LK = 3'd0, PR = 3'd1, IN = 3'd2, IV = 3'd3, VC = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] addr;
        logic        sec;
        logic [2:0]  idx;
        logic        ehit;
        logic [2:0]  eidx;
        logic [7:0]  emask;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t TBL [NV] = '{
        // R5/R6: fill all eight entries, victims walk from 7 down to 0
        '{VC, 16'h0000, 1'b0, 3'd0, 1'b0, 3'd7, 8'h00},
        '{IN, 16'h1000, 1'b0, 3'd7, 1'b0, 3'd7, 8'h00},
        '{VC, 16'h0000, 1'b0, 3'd0, 1'b0, 3'd6, 8'h00},
        '{IN, 16'h1040, 1'b0, 3'd6, 1'b0, 3'd6, 8'h00},
        '{VC, 16'h0000, 1'b0, 3'd0, 1'b0, 3'd5, 8'h00},
        '{IN, 16'h1080, 1'b0, 3'd5, 1'b0, 3'd5, 8'h00},
        '{VC, 16'h0000, 1'b0, 3'd0, 1'b0, 3'd4, 8'h00},
        '{IN, 16'h10C0, 1'b0, 3'd4, 1'b0, 3'd4, 8'h00},
        '{VC, 16'h0000, 1'b0, 3'd0, 1'b0, 3'd3, 8'h00},
        '{IN, 16'h1100, 1'b0, 3'd3, 1'b0, 3'd3, 8'h00},
        '{VC, 16'h0000, 1'b0, 3'd0, 1'b0, 3'd2, 8'h00},
        '{IN, 16'h1140, 1'b0, 3'd2, 1'b0, 3'd2, 8'h00},
        '{VC, 16'h0000, 1'b0, 3'd0, 1'b0, 3'd1, 8'h00},
        '{IN, 16'h1180, 1'b0, 3'd1, 1'b0, 3'd1, 8'h00},
        '{VC, 16'h0000, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00},
        '{IN, 16'h11C0, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00},
        // R8: most recent entry fits both tracked sizes
        '{LK, 16'h11C0, 1'b0, 3'd0, 1'b1, 3'd0, 8'h03},
        // R3/R8: least recent entry fits neither
        '{PR, 16'h1000, 1'b0, 3'd0, 1'b1, 3'd7, 8'h00},
        // R1: secure bit differs, then high address bit differs
        '{LK, 16'h1000, 1'b1, 3'd0, 1'b0, 3'd0, 8'h00},
        '{LK, 16'h91C0, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00},
        // R4: rank-2 hits promote and reshuffle
        '{LK, 16'h1140, 1'b0, 3'd0, 1'b1, 3'd2, 8'h02},
        '{LK, 16'h1180, 1'b0, 3'd0, 1'b1, 3'd1, 8'h02},
        '{LK, 16'h11C0, 1'b0, 3'd0, 1'b1, 3'd0, 8'h02},
        '{LK, 16'h1100, 1'b0, 3'd0, 1'b1, 3'd3, 8'h02},
        // R3: repeated probe of a rank-3 entry gives the same mask
        '{PR, 16'h1140, 1'b0, 3'd0, 1'b1, 3'd2, 8'h02},
        '{PR, 16'h1140, 1'b0, 3'd0, 1'b1, 3'd2, 8'h02},
        // R8: rank 4 is outside both tracked sizes
        '{LK, 16'h10C0, 1'b0, 3'd0, 1'b1, 3'd4, 8'h00},
        // R5: oldest untouched entry
        '{VC, 16'h0000, 1'b0, 3'd0, 1'b0, 3'd7, 8'h00},
        // R7: invalidate the most recent entry, it becomes the victim
        '{IV, 16'h0000, 1'b0, 3'd4, 1'b0, 3'd4, 8'h00},
        '{VC, 16'h0000, 1'b0, 3'd0, 1'b0, 3'd4, 8'h00},
        '{PR, 16'h10C0, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00},
        '{LK, 16'h1100, 1'b0, 3'd0, 1'b1, 3'd3, 8'h03},
        // R6: refill the freed entry
        '{IN, 16'h1200, 1'b0, 3'd4, 1'b0, 3'd4, 8'h00},
        '{PR, 16'h1200, 1'b0, 3'd0, 1'b1, 3'd4, 8'h03},
        '{VC, 16'h0000, 1'b0, 3'd0, 1'b0, 3'd7, 8'h00}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [15:0] addr, input logic sec,
                         input logic [2:0] idx);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_secure = sec; req_idx = idx;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        issue(VC, 16'h0, 1'b0, 3'd0);
        check("R2 reset victim", 32'(rsp_idx), 32'd7);
        issue(PR, 16'h0000, 1'b0, 3'd0);
        check("R2 reset probe miss", 32'(rsp_hit), 32'd0);
        check("R2 reset acc", 32'(acc_cnt), 32'd0);
        check("R2 reset hits", 32'(hit_cnt), 32'd0);
        check("R2 reset misses", 32'(miss_cnt), 32'd0);

        // R6: insert with req_valid low has no effect
        @(negedge clk);
        req_valid = 1'b0; req_op = IN; req_addr = 16'h1080; req_idx = 3'd7;
        issue(PR, 16'h1080, 1'b0, 3'd0);
        check("R6 ignored insert probe", 32'(rsp_hit), 32'd0);
        issue(VC, 16'h0, 1'b0, 3'd0);
        check("R6 ignored insert victim", 32'(rsp_idx), 32'd7);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            issue(TBL[i].op, TBL[i].addr, TBL[i].sec, TBL[i].idx);
            check($sformatf("R1/R4/R5 row %0d hit", i), 32'(rsp_hit), 32'(TBL[i].ehit));
            check($sformatf("R1/R4/R5 row %0d idx", i), 32'(rsp_idx), 32'(TBL[i].eidx));
            check($sformatf("R8 row %0d mask", i), 32'(rsp_mask), 32'(TBL[i].emask));
        end
        idle();

        // R9: nine lookups, small size hit 2, large size hit 6
        check("R9 acc", 32'(acc_cnt), 32'd9);
        check("R9 hits size0", 32'(hit_cnt[0 +: CW]), 32'd2);
        check("R9 misses size0", 32'(miss_cnt[0 +: CW]), 32'd7);
        check("R9 hits size1", 32'(hit_cnt[CW +: CW]), 32'd6);
        check("R9 misses size1", 32'(miss_cnt[CW +: CW]), 32'd3);

        // R10: saturation after a fresh reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 300; i++) issue(LK, 16'h2000, 1'b0, 3'd0);
        idle();
        check("R10 acc saturated", 32'(acc_cnt), 32'd255);
        check("R10 misses size0 saturated", 32'(miss_cnt[0 +: CW]), 32'd255);
        check("R10 misses size1 saturated", 32'(miss_cnt[CW +: CW]), 32'd255);
        check("R10 hits stay zero", 32'(hit_cnt), 32'd0);

        finish_run();
    end
endmodule